// File: doc/BRIEF.md
# Row and Column Repair Matcher

This block is the address-side repair decoder for a memory of 8224 words by 14 bits, built with a 16-way column mux. The stored data is split into a low half and a high half. Each half owns three spare resources: one column spare, one row spare for the large bottom bank (rows 0 to 511), and one row spare for the small top bank (rows 512 and 513). Every spare has its own active-high enable and a fuse address that is held static while the memory runs.

On each access the block splits the address into a column field (the four low bits) and a row field (the upper ten bits). It then compares each enabled fuse against the field it repairs. For each half it reports which spare, if any, the datapath must steer that access to. A row spare outranks a column spare within the same half. The two halves are decoded independently.

The decode is purely combinational. It has no clock, no reset and no flow control: each access is a single address presented on a plain bus, and the select outputs follow it in the same cycle. Because no data moves through the block, it needs no valid/ready handshake and has no back-pressure rules.

Top module: `repair_matcher`

## Requirements
- R1: The address splits into a column field `addr[3:0]` and a row field `addr[13:4]`. Only word addresses 0 to 8223 (rows 0 to 513) are in range. An address of 8224 or above produces no hit in either half.
- R2: The column spare of half h is selected when `col_en[h]` is 1, `col_fuse[h]` equals `addr[3:0]`, the address is in range (any row 0 to 513), and no row spare of half h hits.
- R3: The bottom-bank row spare of half h hits when `bot_en[h]` is 1, the row field is below 512, and `bot_fuse[h]` (9 bits) equals row bits [8:0], that is `addr[12:4]`.
- R4: The top-bank row spare of half h hits when `top_en[h]` is 1, the row field is 512 or 513, and the 1-bit `top_fuse[h]` equals row bit 0, that is `addr[4]`.
- R5: A bottom-bank row spare never hits for rows 512 and above. A top-bank row spare never hits for rows below 512, even when their fuse bits match.
- R6: Index 0 of every per-half port is the low data half and index 1 is the high half. Spares of one half never change the outputs of the other half.
- R7: When a row spare and the column spare of the same half both match, the row spare is selected and `col_hit[h]` is 0.
- R8: A spare whose enable is 0 never causes a hit, whatever its fuse holds. With all enables at 0, every output is 0.
- R9: `sel[h]` encodes the choice as 2'b00 none, 2'b01 column spare, 2'b10 bottom row spare, 2'b11 top row spare. `row_hit[h]` is 1 exactly when `sel[h][1]` is 1, and `col_hit[h]` is 1 exactly when `sel[h]` is 2'b01.
- R10: All outputs are combinational functions of the address and fuse inputs and settle in the same cycle as the address, with no clocked stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr | input | 14 | Word address of the current access |
| col_en | input | 2 | Column spare enable per half |
| col_fuse | input | 2x4 | Column fuse address per half |
| bot_en | input | 2 | Bottom-bank row spare enable per half |
| bot_fuse | input | 2x9 | Bottom-bank row fuse address per half |
| top_en | input | 2 | Top-bank row spare enable per half |
| top_fuse | input | 2x1 | Top-bank row fuse bit per half |
| row_hit | output | 2 | A row spare serves this access, per half |
| col_hit | output | 2 | The column spare serves this access, per half |
| sel | output | 2x2 | Encoded spare choice per half |

## Verification
The hardest case to reach is the one where a row spare and the column spare of the same half both match on one access. A uniformly random 14-bit address almost never lines up with two independent fuses at once. The bench therefore builds half of its random addresses from the programmed fuses: it takes the row from a bottom or top fuse and the column from a column fuse. This places collisions, fuse hits at the bank boundary, and in-range row 513 accesses regularly among the random traffic. Directed accesses at rows 511, 512 and 513 and at word 8224 pin down the bank and range edges.

// File: rtl/repair_pkg.sv
package repair_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'b00,
    SEL_COL  = 2'b01,
    SEL_BOT  = 2'b10,
    SEL_TOP  = 2'b11
  } spare_sel_t;
endpackage

// File: rtl/addr_split.sv
module addr_split #(
  parameter int unsigned ADDR_W   = 14,
  parameter int unsigned COL_W    = 4,
  parameter int unsigned WORDS    = 8224,
  parameter int unsigned BOT_ROWS = 512,
  localparam int unsigned ROW_W   = ADDR_W - COL_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [COL_W-1:0]  col,
  output logic [ROW_W-1:0]  row,
  output logic              in_range,
  output logic              in_bot,
  output logic              in_top
);
  localparam logic [ADDR_W-1:0] WORD_LIM = ADDR_W'(WORDS);
  localparam logic [ROW_W-1:0]  BOT_LIM  = ROW_W'(BOT_ROWS);

  always_comb begin
    col      = addr[COL_W-1:0];
    row      = addr[ADDR_W-1:COL_W];
    in_range = (addr < WORD_LIM);
    in_bot   = in_range && (row < BOT_LIM);
    in_top   = in_range && (row >= BOT_LIM);
  end
endmodule

// File: rtl/fuse_cmp.sv
module fuse_cmp #(
  parameter int unsigned W = 4
) (
  input  logic         en,
  input  logic         gate,
  input  logic [W-1:0] fuse,
  input  logic [W-1:0] key,
  output logic         hit
);
  always_comb hit = en && gate && (fuse == key);
endmodule

// File: rtl/half_arbiter.sv
module half_arbiter
  import repair_pkg::*;
(
  input  logic       col_m,
  input  logic       bot_m,
  input  logic       top_m,
  output spare_sel_t sel
);
  always_comb begin
    if (top_m)      sel = SEL_TOP;
    else if (bot_m) sel = SEL_BOT;
    else if (col_m) sel = SEL_COL;
    else            sel = SEL_NONE;
  end
endmodule

// File: rtl/repair_matcher.sv
module repair_matcher
  import repair_pkg::*;
#(
  parameter int unsigned ADDR_W   = 14,
  parameter int unsigned COL_W    = 4,
  parameter int unsigned WORDS    = 8224,
  parameter int unsigned BOT_ROWS = 512,
  parameter int unsigned TOP_FW   = 1,
  parameter int unsigned NHALF    = 2,
  localparam int unsigned ROW_W   = ADDR_W - COL_W,
  localparam int unsigned BOT_FW  = $clog2(BOT_ROWS)
) (
  input  logic [ADDR_W-1:0]             addr,
  input  logic [NHALF-1:0]              col_en,
  input  logic [NHALF-1:0][COL_W-1:0]   col_fuse,
  input  logic [NHALF-1:0]              bot_en,
  input  logic [NHALF-1:0][BOT_FW-1:0]  bot_fuse,
  input  logic [NHALF-1:0]              top_en,
  input  logic [NHALF-1:0][TOP_FW-1:0]  top_fuse,
  output logic [NHALF-1:0]              row_hit,
  output logic [NHALF-1:0]              col_hit,
  output logic [NHALF-1:0][1:0]         sel
);
  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row;
  logic             in_range, in_bot, in_top;

  addr_split #(
    .ADDR_W(ADDR_W), .COL_W(COL_W), .WORDS(WORDS), .BOT_ROWS(BOT_ROWS)
  ) u_split (
    .addr(addr), .col(col), .row(row),
    .in_range(in_range), .in_bot(in_bot), .in_top(in_top)
  );

  logic [NHALF-1:0] col_m, bot_m, top_m;
  spare_sel_t       arb_sel [NHALF];

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    fuse_cmp #(.W(COL_W)) u_col (
      .en(col_en[h]), .gate(in_range), .fuse(col_fuse[h]),
      .key(col), .hit(col_m[h])
    );
    fuse_cmp #(.W(BOT_FW)) u_bot (
      .en(bot_en[h]), .gate(in_bot), .fuse(bot_fuse[h]),
      .key(row[BOT_FW-1:0]), .hit(bot_m[h])
    );
    fuse_cmp #(.W(TOP_FW)) u_top (
      .en(top_en[h]), .gate(in_top), .fuse(top_fuse[h]),
      .key(row[TOP_FW-1:0]), .hit(top_m[h])
    );
    half_arbiter u_arb (
      .col_m(col_m[h]), .bot_m(bot_m[h]), .top_m(top_m[h]),
      .sel(arb_sel[h])
    );

    always_comb begin
      sel[h]     = arb_sel[h];
      row_hit[h] = bot_m[h] | top_m[h];
      col_hit[h] = (arb_sel[h] == SEL_COL);
    end

    always_comb begin
      if (row_hit[h]) AST_ROW_BEATS_COL: assert (!col_hit[h]) else $error("row and column both selected"); // R7
      if (!in_range) AST_OUT_OF_RANGE_QUIET: assert (arb_sel[h] == SEL_NONE) else $error("hit beyond last word"); // R1
      if (arb_sel[h] == SEL_BOT) AST_BOT_BANK_ONLY: assert (in_bot) else $error("bottom spare outside its bank"); // R5
      if (arb_sel[h] == SEL_TOP) AST_TOP_BANK_ONLY: assert (in_top) else $error("top spare outside its bank"); // R5
      if (!col_en[h]) AST_COL_OFF_QUIET: assert (arb_sel[h] != SEL_COL) else $error("disabled column spare hit"); // R8
      if (!bot_en[h]) AST_BOT_OFF_QUIET: assert (arb_sel[h] != SEL_BOT) else $error("disabled bottom spare hit"); // R8
      if (!top_en[h]) AST_TOP_OFF_QUIET: assert (arb_sel[h] != SEL_TOP) else $error("disabled top spare hit"); // R8
      AST_SEL_ROW_FLAG: assert (row_hit[h] == arb_sel[h][1]) else $error("row flag disagrees with code"); // R9
    end
  end
endmodule

// File: tb/sim_repair_matcher.sv
module sim_repair_matcher;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [13:0]      addr = '0;
  logic [1:0]       col_en = '0, bot_en = '0, top_en = '0;
  logic [1:0][3:0]  col_fuse = '0;
  logic [1:0][8:0]  bot_fuse = '0;
  logic [1:0][0:0]  top_fuse = '0;
  logic [1:0]       row_hit, col_hit;
  logic [1:0][1:0]  sel;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 0;

  repair_matcher u0 (
    .addr(addr), .col_en(col_en), .col_fuse(col_fuse),
    .bot_en(bot_en), .bot_fuse(bot_fuse), .top_en(top_en), .top_fuse(top_fuse),
    .row_hit(row_hit), .col_hit(col_hit), .sel(sel)
  );

  function automatic logic [1:0] ref_sel(int h, logic [13:0] a);
    logic [9:0] r = a[13:4];
    if (a >= 14'd8224) return 2'b00;
    if (top_en[h] && r >= 10'd512 && top_fuse[h][0] == r[0]) return 2'b11;
    if (bot_en[h] && r < 10'd512 && bot_fuse[h] == r[8:0]) return 2'b10;
    if (col_en[h] && col_fuse[h] == a[3:0]) return 2'b01;
    return 2'b00;
  endfunction

  task automatic access(logic [13:0] a, string tag);
    @(negedge clk);
    addr = a;
    #1;
    for (int h = 0; h < 2; h++) begin
      logic [1:0] e = ref_sel(h, a);
      n_chk++;
      if (sel[h] !== e || row_hit[h] !== e[1] || col_hit[h] !== (e == 2'b01)) begin
        n_bad++;
        $display("FAIL %s half%0d addr=%0d sel/row/col=%b/%b/%b expected %b/%b/%b",
                 tag, h, a, sel[h], row_hit[h], col_hit[h], e, e[1], (e == 2'b01));
      end
    end
  endtask

  function automatic logic [13:0] mk(int r, int c);
    return 14'((r << 4) | c);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240917));
    repeat (3) @(negedge clk);
    // R8 reset state: nothing enabled, fuses zero
    access(mk(0, 0), "R8 reset");
    access(mk(512, 0), "R8 reset");
    // R8: fuses match but enables are off
    @(negedge clk);
    col_fuse = '{4'd9, 4'd5}; bot_fuse = '{9'd300, 9'd100}; top_fuse = '{1'b0, 1'b1};
    access(mk(100, 5), "R8 off");
    access(mk(513, 5), "R8 off");
    @(negedge clk);
    col_en = 2'b11; bot_en = 2'b11; top_en = 2'b11;
    access(mk(7, 5), "R2 R6 low column");
    access(mk(7, 9), "R2 R6 high column");
    access(mk(100, 9), "R3 R6 low bottom row");
    access(mk(300, 3), "R3 high bottom row");
    access(mk(100, 5), "R7 row beats column");
    access(mk(513, 3), "R4 top row low half");
    access(mk(512, 9), "R4 R7 top row high half");
    access(mk(511, 9), "R5 row 511");
    access(14'd8223, "R1 last word");
    @(negedge clk);
    col_fuse = '{4'd0, 4'd0};
    access(14'd8224, "R1 first word out of range");
    access(mk(516, 5), "R1 out of range");
    // R5: bottom fuse 0 must not match row 512, top fuse 0 must not match row 0
    @(negedge clk);
    top_en = 2'b00; bot_fuse = '{9'd0, 9'd0}; col_en = 2'b00;
    access(mk(512, 1), "R5 bottom spare at 512");
    access(mk(0, 1), "R5 bottom spare at 0");
    @(negedge clk);
    bot_en = 2'b00; top_en = 2'b11; top_fuse = '{1'b0, 1'b0};
    access(mk(0, 1), "R5 top spare at row 0");
    access(mk(512, 1), "R5 top spare at 512");
    // R8: one half disabled, the other still hits (R6)
    @(negedge clk);
    top_en = 2'b10;
    access(mk(512, 2), "R8 R6 half enable");

    for (int i = 0; i < 4000; i++) begin
      logic [13:0] a;
      if (i % 40 == 0) begin
        @(negedge clk);
        col_en = 2'($urandom); bot_en = 2'($urandom); top_en = 2'($urandom);
        for (int h = 0; h < 2; h++) begin
          col_fuse[h] = 4'($urandom);
          bot_fuse[h] = 9'($urandom);
          top_fuse[h] = 1'($urandom);
        end
      end
      if ($urandom % 2 == 0) begin
        a = 14'($urandom);
      end else begin
        int h = int'($urandom % 2);
        int r = ($urandom % 3 == 0) ? (512 + int'(top_fuse[h][0]) + ($urandom % 2 == 0 ? 0 : 2))
                                    : int'(bot_fuse[h]);
        a = mk(r, int'(col_fuse[$urandom % 2]));
      end
      access(a, "R10 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule